// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter Stage

This block is one stage of a synchronous binary up-counter. It is built so that several stages can be chained into one wider counter that still changes all bits on the same clock edge. Each stage keeps a small count register. Every bit of that register updates together on the rising edge of the clock. A low level on an asynchronous clear input empties the register at once. A low level on a synchronous load input copies a parallel data word into the register on the next edge.

The stage has two active-high count enables. The parallel enable only gates counting. The trickle enable gates counting and is also passed forward into the carry output. The carry output is high while the count is at its maximum and the trickle enable is high. To build a wider counter, connect each stage's carry to the trickle enable of the next, more significant stage. Tie the parallel enables high, or drive them all from one shared count-enable signal.

Top module: `sync_count_stage`

## Requirements
- R1: While `clr_n` is low, `count` is 0 and `carry` is 0 at once, with no clock edge needed. `count` stays 0 across rising edges while `clr_n` is low, whatever `load_n`, `din`, `en_par` and `en_trk` are doing.
- R2: If `load_n` is low at a rising edge of `clk`, `count` takes the value of `din` after that edge. This holds whatever the levels of `en_par` and `en_trk`.
- R3: If `load_n`, `en_par` and `en_trk` are all high at a rising edge, `count` goes up by one. From the all-ones value it wraps to 0. Bit 0 of `count` is the least significant bit.
- R4: If `load_n` is high and at least one of `en_par` or `en_trk` is low at a rising edge, `count` keeps its value.
- R5: `carry` is high exactly when `en_trk` is high and every bit of `count` is 1. It follows `en_trk` without waiting for a clock edge, and `en_par` has no effect on it.
- R6: The following sequence is reproduced exactly: clear to 0, preset to 12, count to 13, 14, 15, 0, 1 and 2, then inhibit with the value held at 2.
- R7: Chain two stages: the low stage's `carry` drives the high stage's `en_trk`, and the high stage's `en_par` is tied high. The pair then counts 0 to 255 as one 8-bit counter, with the high stage's count as the upper four bits, and wraps to 0. The high stage's `carry` is high only at 255.
- R8: Loading the all-ones value while `en_trk` is high raises `carry` directly after that edge, without any counting step.
- R9: Changes on `load_n`, `en_par` or `en_trk` between clock edges leave `count` unchanged until the next rising edge. Only the levels present at the edge decide what happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| din | input | WIDTH | Parallel preset data |
| en_par | input | 1 | Parallel count enable, active high |
| en_trk | input | 1 | Trickle count enable, also gates `carry` |
| count | output | WIDTH | Current count, bit 0 least significant |
| carry | output | 1 | High when `en_trk` is high and `count` is all ones |

## Verification
A load and a count request can arrive at the same edge. The bench makes this happen by holding `load_n` low while both enables are high, and then checks that `count` equals `din` rather than the incremented value. The clear and a load can also overlap. The bench holds `clr_n` low across an edge at which a load of all ones is requested, and checks that `count` and `carry` stay at zero. In the chained pair, the low stage's wrap and the high stage's increment fall on the same edge. The bench checks that 8-bit value before every edge from 0 to 255 and once more after the wrap back to 0.

// File: rtl/cnt_stage_pkg.sv
package cnt_stage_pkg;
   // Action applied to the count register at the next rising edge
   typedef enum logic [1:0] {
      CM_HOLD  = 2'd0,
      CM_LOAD  = 2'd1,
      CM_COUNT = 2'd2
   } cnt_mode_e;
endpackage

// File: rtl/cnt_stage_ctrl.sv
module cnt_stage_ctrl
   import cnt_stage_pkg::*;
(
   input  logic      load_n,
   input  logic      en_par,
   input  logic      en_trk,
   output cnt_mode_e mode
);
   // Load wins over counting; counting needs both enables; otherwise hold
   always_comb begin
      if (!load_n)
         mode = CM_LOAD;
      else if (en_par && en_trk)
         mode = CM_COUNT;
      else
         mode = CM_HOLD;
   end
endmodule

// File: rtl/cnt_stage_reg.sv
module cnt_stage_reg
   import cnt_stage_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             clr_n,
   input  cnt_mode_e        mode,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q
);
   localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

   initial begin
      width_range_chk: assert (WIDTH >= 1 && WIDTH <= 32)
         else $error("cnt_stage_reg: WIDTH out of range");
   end

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)
         q <= '0;
      else begin
         unique case (mode)
            CM_LOAD:  q <= din;
            CM_COUNT: q <= q + STEP;
            default:  q <= q;
         endcase
      end
   end

   // R1
   clear_zero_chk: assert property (@(posedge clk) !clr_n |-> q == '0);

   // R2
   load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
      mode == CM_LOAD |=> q == $past(din));

   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
      mode == CM_COUNT |=> q == WIDTH'($past(q) + STEP));

   // R4
   hold_keep_chk: assert property (@(posedge clk) disable iff (!clr_n)
      mode == CM_HOLD |=> $stable(q));
endmodule

// File: rtl/cnt_stage_carry.sv
module cnt_stage_carry #(
   parameter int WIDTH     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic [WIDTH-1:0] q,
   input  logic             en_trk,
   output logic             carry
);
   logic full;

   generate
      if (LOOKAHEAD) begin : g_flat
         // single wide AND: one gate level for small widths
         assign full = &q;
      end else begin : g_chain
         // serial AND chain: one two-input gate per bit
         logic [WIDTH:0] acc;
         assign acc[0] = 1'b1;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign acc[i+1] = acc[i] & q[i];
         end
         assign full = acc[WIDTH];
      end
   endgenerate

   assign carry = en_trk & full;
endmodule

// File: rtl/sync_count_stage.sv
module sync_count_stage
   import cnt_stage_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             load_n,
   input  logic [WIDTH-1:0] din,
   input  logic             en_par,
   input  logic             en_trk,
   output logic [WIDTH-1:0] count,
   output logic             carry
);
   cnt_mode_e mode;

   cnt_stage_ctrl u_ctrl (
      .load_n (load_n),
      .en_par (en_par),
      .en_trk (en_trk),
      .mode   (mode)
   );

   cnt_stage_reg #(.WIDTH(WIDTH)) u_reg (
      .clk   (clk),
      .clr_n (clr_n),
      .mode  (mode),
      .din   (din),
      .q     (count)
   );

   cnt_stage_carry #(.WIDTH(WIDTH), .LOOKAHEAD(LOOKAHEAD)) u_carry (
      .q      (count),
      .en_trk (en_trk),
      .carry  (carry)
   );

   // R5
   carry_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
      (carry && en_par && load_n) |=> count == '0);

   // R5
   carry_trk_chk: assert property (@(posedge clk) disable iff (!clr_n)
      !en_trk |-> !carry);

   // R8
   load_full_carry_chk: assert property (@(posedge clk) disable iff (!clr_n)
      (!load_n && en_trk && (&din)) |=> carry);
endmodule

// File: tb/sync_count_stage_tb.sv
module sync_count_stage_tb;
   logic       clk = 1'b0;
   logic       clr_n;
   logic       load_n;
   logic [3:0] din;
   logic       en_par;
   logic       en_trk;
   logic [3:0] cnt_lo, cnt_hi;
   logic       carry_lo, carry_hi;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   sync_count_stage u_dut (
      .clk (clk), .clr_n (clr_n), .load_n (load_n), .din (din),
      .en_par (en_par), .en_trk (en_trk), .count (cnt_lo), .carry (carry_lo)
   );

   sync_count_stage u_hi (
      .clk (clk), .clr_n (clr_n), .load_n (1'b1), .din (4'd0),
      .en_par (1'b1), .en_trk (carry_lo), .count (cnt_hi), .carry (carry_hi)
   );

   // vector: [11] load_n [10] en_par [9] en_trk [8:5] din [4:1] count [0] carry
   localparam logic [11:0] VEC [0:13] = '{
      12'b000_1100_1100_0,  // R6 preset 12
      12'b111_0000_1101_0,  // R6 13
      12'b111_0000_1110_0,  // R6 14
      12'b111_0000_1111_1,  // R6 15, carry high
      12'b111_0000_0000_0,  // R6 wrap to 0
      12'b111_0000_0001_0,  // R6 1
      12'b111_0000_0010_0,  // R6 2
      12'b101_0000_0010_0,  // R6 inhibit, parallel enable low
      12'b110_0000_0010_0,  // R4 inhibit, trickle enable low
      12'b001_1111_1111_1,  // R8 load all ones
      12'b101_0000_1111_1,  // R5 carry with en_par low
      12'b110_0000_1111_0,  // R5 carry dropped by en_trk
      12'b011_0101_0101_0,  // R2 load beats both enables
      12'b111_0000_0110_0   // R3 count
   };

   function automatic string vec_req(int i);
      if (i <= 7)  return "R6";
      if (i == 8)  return "R4";
      if (i == 9)  return "R8";
      if (i <= 11) return "R5";
      if (i == 12) return "R2";
      return "R3";
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      clr_n = 1'b0; load_n = 1'b1; din = 4'd0; en_par = 1'b0; en_trk = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      // R1 reset state
      check(cnt_lo == 4'd0, "R1", cnt_lo, 0);
      check(carry_lo == 1'b0, "R1", carry_lo, 0);
      clr_n = 1'b1;

      // vector table walk
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         {load_n, en_par, en_trk, din} = VEC[i][11:5];
         @(posedge clk);
         #1;
         check(cnt_lo == VEC[i][4:1], vec_req(i), cnt_lo, VEC[i][4:1]);
         check(carry_lo == VEC[i][0], vec_req(i), carry_lo, VEC[i][0]);
      end

      // R9: control changes between edges do not touch the count
      @(negedge clk);
      load_n = 1'b0; din = 4'd9; en_par = 1'b0; en_trk = 1'b0;
      @(posedge clk); #1;
      check(cnt_lo == 4'd9, "R9", cnt_lo, 9);
      @(negedge clk);
      load_n = 1'b0; din = 4'd3; en_par = 1'b1; en_trk = 1'b1;
      #1;
      check(cnt_lo == 4'd9, "R9", cnt_lo, 9);
      load_n = 1'b1; en_par = 1'b0;
      @(posedge clk); #1;
      check(cnt_lo == 4'd9, "R9", cnt_lo, 9);

      // R1: clear mid-cycle, then held across an edge requesting a load of all ones
      @(negedge clk);
      #1 clr_n = 1'b0;
      #1;
      check(cnt_lo == 4'd0, "R1", cnt_lo, 0);
      load_n = 1'b0; din = 4'hF; en_par = 1'b1; en_trk = 1'b1;
      @(posedge clk); #1;
      check(cnt_lo == 4'd0, "R1", cnt_lo, 0);
      check(carry_lo == 1'b0, "R1", carry_lo, 0);
      @(negedge clk);
      clr_n = 1'b1; load_n = 1'b1; en_par = 1'b1; en_trk = 1'b1;

      // R7: chained pair as an 8-bit counter
      @(negedge clk);
      clr_n = 1'b0;
      @(negedge clk);
      clr_n = 1'b1;
      for (int i = 0; i < 256; i++) begin
         check({cnt_hi, cnt_lo} == 8'(i), "R7", {cnt_hi, cnt_lo}, i);
         check(carry_hi == (i == 255), "R7", carry_hi, (i == 255));
         @(negedge clk);
      end
      check({cnt_hi, cnt_lo} == 8'd0, "R7", {cnt_hi, cnt_lo}, 0);

      summary();
      $finish;
   end
endmodule